// File: doc/BRIEF.md
# Double-Buffered Bulk OUT Endpoint

This block is the receive side of a full-speed bulk OUT endpoint. Packets arrive from a serial engine. The engine signals a token, a stream of data bytes, and an end strobe that carries a pass/fail result from its error check. Each packet is written into one of two ping-pong buffers, each sized for the largest packet. The endpoint then answers the host with a handshake. If a free buffer exists, it acknowledges a good packet. If both buffers still hold unread data, it refuses the packet. It sends no handshake at all for a packet that failed the check or overran the buffer.

On the processor side, a small status word shows three things: whether any buffer holds a packet, a sticky completion flag that software clears by writing a 1, and the byte count of the packet that is next in line to be read. A pop strobe steps through that packet one byte at a time. The older packet is always read first, and a buffer is released once its last byte has been popped. The interrupt output follows the completion flag whenever the enable input is high.

Top module: `bulk_out_ep`

## Requirements
- R1: After reset, `csr_rdata` reads 0, `irq` is low and `hs_valid` is low.
- R2: A packet of 1 to 64 bytes whose end strobe has `rx_good`=1 is stored in a free buffer. This holds whatever the completion flag is. In the cycle after the end strobe, `hs_valid`=1 and `hs_ack`=1. The status word then shows bit 0 (service) = 1, bit 1 (completion) = 1, and bits 10:4 = the byte count.
- R3: A zero-length good packet is acknowledged and sets bits 0 and 1 with a count of 0. A single pop releases its buffer.
- R4: A packet with `rx_good`=0, or one longer than 64 bytes, gets no handshake. It sets neither status bit, and its buffer stays free for the next packet.
- R5: Writing a word with bit 1 set clears the completion flag. Writing bit 1 as 0 leaves the flag unchanged.
- R6: `irq` equals completion flag AND `irq_en`.
- R7: When both buffers hold unread data, a good packet is answered with `hs_valid`=1, `hs_ack`=0, and its bytes are not stored.
- R8: `rd_data` shows the current byte of the older full buffer, in arrival order. Each `rd_pop` advances to the next byte, and popping the last byte releases the buffer.
- R9: Bit 0 stays 1 until both buffers have been drained. After the older packet is drained, bits 10:4 show the count of the newer one.
- R10: Status bits 2 and 3 always read 0.
- R11: Bytes and end strobes that arrive without a preceding token are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_out | input | 1 | One-cycle pulse: an OUT token for this endpoint has arrived |
| rx_valid | input | 1 | A data byte is present on `rx_byte` |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | One-cycle end-of-packet strobe |
| rx_good | input | 1 | Error-check result, qualified by `rx_eop` |
| hs_valid | output | 1 | A handshake is to be sent this cycle |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK, qualified by `hs_valid` |
| csr_wr | input | 1 | Status-word write strobe |
| csr_wdata | input | 16 | Write data; bit 1 clears the completion flag |
| csr_rdata | output | 16 | Status word: bit 0 service, bit 1 completion, bits 3:2 zero, bits 10:4 count |
| rd_pop | input | 1 | Consume the current byte of the older full buffer |
| rd_data | output | 8 | Current byte of the older full buffer |
| irq_en | input | 1 | Receive interrupt enable |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is the refusal case. Both buffers must be full while the completion flag is set, and the bench must then confirm that the refused packet left no trace. To get there, the stimulus sends two good packets back to back without clearing the flag or popping any data. It then sends a third packet and expects a NAK. Afterwards it drains both buffers in order, checking every byte and the count shown at each step. The service bit must drop exactly when the second buffer empties, which shows that the refused bytes were never stored.

// File: rtl/bout_pkg.sv
package bout_pkg;
   localparam int STAT_SVC_BIT  = 0;
   localparam int STAT_DONE_BIT = 1;
   localparam int STAT_CNT_LSB  = 4;
endpackage

// File: rtl/bout_buf.sv
module bout_buf #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/bout_rx_ctl.sv
module bout_rx_ctl #(
   parameter int MAX_PKT = 64,
   parameter int DW      = 8,
   localparam int CNT_W  = $clog2(MAX_PKT + 1),
   localparam int AW     = $clog2(MAX_PKT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok,
   input  logic             rx_valid,
   input  logic [DW-1:0]    rx_byte,
   input  logic             rx_eop,
   input  logic             rx_good,
   input  logic             can_take,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [DW-1:0]    wr_data,
   output logic             commit,
   output logic [CNT_W-1:0] commit_len,
   output logic             hs_valid,
   output logic             hs_ack
);
   logic             active_q, take_q, ovf_q, hs_v_q, hs_a_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_end, pkt_ok;

   assign at_end     = (cnt_q == CNT_W'(MAX_PKT));
   assign pkt_ok     = active_q & rx_eop & rx_good & ~ovf_q;
   assign commit     = pkt_ok & take_q;
   assign commit_len = cnt_q;
   assign wr_en      = active_q & take_q & rx_valid & ~at_end;
   assign wr_addr    = cnt_q[AW-1:0];
   assign wr_data    = rx_byte;
   assign hs_valid   = hs_v_q;
   assign hs_ack     = hs_a_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         take_q   <= 1'b0;
         ovf_q    <= 1'b0;
         cnt_q    <= '0;
         hs_v_q   <= 1'b0;
         hs_a_q   <= 1'b0;
      end else begin
         hs_v_q <= pkt_ok;
         hs_a_q <= commit;
         if (tok) begin
            active_q <= 1'b1;
            take_q   <= can_take;
            ovf_q    <= 1'b0;
            cnt_q    <= '0;
         end else if (active_q) begin
            if (rx_eop) begin
               active_q <= 1'b0;
               take_q   <= 1'b0;
            end else if (rx_valid) begin
               if (at_end) ovf_q <= 1'b1;
               else        cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bout_rd_ctl.sv
module bout_rd_ctl #(
   parameter int MAX_PKT = 64,
   localparam int CNT_W  = $clog2(MAX_PKT + 1),
   localparam int AW     = $clog2(MAX_PKT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop,
   input  logic             head_full,
   input  logic [CNT_W-1:0] head_len,
   output logic [AW-1:0]    rd_idx,
   output logic             release_buf
);
   logic [AW-1:0] idx_q;
   logic          last;

   assign last        = (head_len == '0) || ((CNT_W'(idx_q) + 1'b1) == head_len);
   assign release_buf = pop & head_full & last;
   assign rd_idx      = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  idx_q <= '0;
      else if (pop && head_full)   idx_q <= last ? '0 : idx_q + 1'b1;
   end
endmodule

// File: rtl/bulk_out_ep.sv
module bulk_out_ep
   import bout_pkg::*;
#(
   parameter int MAX_PKT = 64,
   parameter int DW      = 8,
   parameter int CSR_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_out,
   input  logic             rx_valid,
   input  logic [DW-1:0]    rx_byte,
   input  logic             rx_eop,
   input  logic             rx_good,
   output logic             hs_valid,
   output logic             hs_ack,
   input  logic             csr_wr,
   input  logic [CSR_W-1:0] csr_wdata,
   output logic [CSR_W-1:0] csr_rdata,
   input  logic             rd_pop,
   output logic [DW-1:0]    rd_data,
   input  logic             irq_en,
   output logic             irq
);
   localparam int CNT_W = $clog2(MAX_PKT + 1);
   localparam int AW    = $clog2(MAX_PKT);
   localparam int NBUF  = 2;

   initial begin
      if (CSR_W < STAT_CNT_LSB + CNT_W) $error("CSR_W too narrow for count field");
      if (MAX_PKT < 2) $error("MAX_PKT must be at least 2");
   end

   logic [NBUF-1:0]  full_q;
   logic [CNT_W-1:0] len_q [NBUF];
   logic             wr_ptr_q, rd_ptr_q, rpc_q;

   logic             wr_en, commit, free_w;
   logic [AW-1:0]    wr_addr, rd_idx;
   logic [DW-1:0]    wr_data;
   logic [CNT_W-1:0] commit_len;
   logic [DW-1:0]    buf_rd [NBUF];

   logic unused_wdata;
   assign unused_wdata = ^{csr_wdata[CSR_W-1:STAT_DONE_BIT+1], csr_wdata[STAT_DONE_BIT-1:0]};

   bout_rx_ctl #(.MAX_PKT(MAX_PKT), .DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .tok(tok_out), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_good(rx_good),
      .can_take(~full_q[wr_ptr_q]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .commit(commit), .commit_len(commit_len),
      .hs_valid(hs_valid), .hs_ack(hs_ack)
   );

   bout_rd_ctl #(.MAX_PKT(MAX_PKT)) u_rd (
      .clk(clk), .rst_n(rst_n), .pop(rd_pop),
      .head_full(full_q[rd_ptr_q]), .head_len(len_q[rd_ptr_q]),
      .rd_idx(rd_idx), .release_buf(free_w)
   );

   for (genvar b = 0; b < NBUF; b++) begin : g_buf
      bout_buf #(.DEPTH(MAX_PKT), .DW(DW)) u_buf (
         .clk(clk),
         .wr_en(wr_en && (wr_ptr_q == 1'(b))),
         .wr_addr(wr_addr), .wr_data(wr_data),
         .rd_addr(rd_idx), .rd_data(buf_rd[b])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            full_q[b] <= 1'b0;
            len_q[b]  <= '0;
         end else if (commit && wr_ptr_q == 1'(b)) begin
            full_q[b] <= 1'b1;
            len_q[b]  <= commit_len;
         end else if (free_w && rd_ptr_q == 1'(b)) begin
            full_q[b] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= 1'b0;
         rd_ptr_q <= 1'b0;
         rpc_q    <= 1'b0;
      end else begin
         if (commit) wr_ptr_q <= ~wr_ptr_q;
         if (free_w) rd_ptr_q <= ~rd_ptr_q;
         if (commit)                                rpc_q <= 1'b1;
         else if (csr_wr && csr_wdata[STAT_DONE_BIT]) rpc_q <= 1'b0;
      end
   end

   assign rd_data = buf_rd[rd_ptr_q];
   assign irq     = rpc_q & irq_en;

   always_comb begin
      csr_rdata = '0;
      csr_rdata[STAT_SVC_BIT]  = |full_q;
      csr_rdata[STAT_DONE_BIT] = rpc_q;
      csr_rdata[STAT_CNT_LSB +: CNT_W] = full_q[rd_ptr_q] ? len_q[rd_ptr_q] : '0;
   end

   assert_done_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> rpc_q);
   assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rpc_q && !(csr_wr && csr_wdata[STAT_DONE_BIT])) |=> rpc_q);
   assert_commit_free_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !full_q[wr_ptr_q]);
   assert_ack_only_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_ack) |-> $past(commit));
   assert_svc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((|full_q) && !free_w) |=> (|full_q));
   assert_no_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && free_w && wr_ptr_q == rd_ptr_q));
endmodule

// File: tb/bulk_out_ep_test.sv
module bulk_out_ep_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tok_out = 0, rx_valid = 0, rx_eop = 0, rx_good = 0;
   logic [7:0]  rx_byte = 0;
   logic        hs_valid, hs_ack;
   logic        csr_wr = 0;
   logic [15:0] csr_wdata = 0;
   logic [15:0] csr_rdata;
   logic        rd_pop = 0;
   logic [7:0]  rd_data;
   logic        irq_en = 0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bulk_out_ep uut (
      .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_good(rx_good),
      .hs_valid(hs_valid), .hs_ack(hs_ack), .csr_wr(csr_wr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rd_pop(rd_pop),
      .rd_data(rd_data), .irq_en(irq_en), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send_pkt(input int n, input logic good, input logic [7:0] seed, input bit with_tok);
      @(negedge clk);
      tok_out = with_tok;
      @(negedge clk);
      tok_out = 0;
      for (int i = 0; i < n; i++) begin
         rx_valid = 1;
         rx_byte  = seed + 8'(i);
         @(negedge clk);
      end
      rx_valid = 0;
      rx_eop   = 1;
      rx_good  = good;
      @(negedge clk);
      rx_eop  = 0;
      rx_good = 0;
   endtask

   task automatic write_csr(input logic [15:0] v);
      csr_wr = 1;
      csr_wdata = v;
      @(negedge clk);
      csr_wr = 0;
      csr_wdata = 0;
   endtask

   task automatic drain(input int n, input logic [7:0] seed, input string req);
      for (int i = 0; i < n; i++) begin
         check(rd_data == seed + 8'(i), req, rd_data, seed + 8'(i));
         rd_pop = 1;
         @(negedge clk);
         rd_pop = 0;
      end
   endtask

   task automatic t_reset;
      check(csr_rdata == 16'h0, "R1", csr_rdata, 0);
      check(irq == 1'b0, "R1", irq, 0);
      check(hs_valid == 1'b0, "R1", hs_valid, 0);
   endtask

   task automatic t_single;
      irq_en = 1;
      send_pkt(5, 1, 8'h10, 1);
      check(hs_valid && hs_ack, "R2", {hs_valid, hs_ack}, 3);
      check(csr_rdata == 16'h0053, "R2", csr_rdata, 16'h0053);
      check(csr_rdata[3:2] == 2'b00, "R10", csr_rdata[3:2], 0);
      check(irq == 1'b1, "R6", irq, 1);
      irq_en = 0;
      #1;
      check(irq == 1'b0, "R6", irq, 0);
      write_csr(16'hFFFD);
      check(csr_rdata[1] == 1'b1, "R5", csr_rdata[1], 1);
      write_csr(16'h0002);
      check(csr_rdata == 16'h0051, "R5", csr_rdata, 16'h0051);
      drain(5, 8'h10, "R8");
      check(csr_rdata == 16'h0, "R8", csr_rdata, 0);
   endtask

   task automatic t_pingpong;
      send_pkt(3, 1, 8'h40, 1);
      check(hs_valid && hs_ack, "R2", {hs_valid, hs_ack}, 3);
      send_pkt(64, 1, 8'h80, 1);
      check(hs_valid && hs_ack, "R2", {hs_valid, hs_ack}, 3);
      send_pkt(2, 1, 8'hC0, 1);
      check(hs_valid && !hs_ack, "R7", {hs_valid, hs_ack}, 2);
      check(csr_rdata == 16'h0033, "R8", csr_rdata, 16'h0033);
      drain(3, 8'h40, "R8");
      check(csr_rdata == 16'h0403, "R9", csr_rdata, 16'h0403);
      drain(64, 8'h80, "R8");
      check(csr_rdata == 16'h0002, "R7", csr_rdata, 16'h0002);
      write_csr(16'h0002);
      check(csr_rdata == 16'h0, "R5", csr_rdata, 0);
   endtask

   task automatic t_zero;
      send_pkt(0, 1, 8'h00, 1);
      check(hs_valid && hs_ack, "R3", {hs_valid, hs_ack}, 3);
      check(csr_rdata == 16'h0003, "R3", csr_rdata, 16'h0003);
      rd_pop = 1;
      @(negedge clk);
      rd_pop = 0;
      check(csr_rdata == 16'h0002, "R3", csr_rdata, 16'h0002);
      write_csr(16'h0002);
   endtask

   task automatic t_bad;
      send_pkt(4, 0, 8'h20, 1);
      check(hs_valid == 1'b0, "R4", hs_valid, 0);
      check(csr_rdata == 16'h0, "R4", csr_rdata, 0);
      send_pkt(65, 1, 8'h30, 1);
      check(hs_valid == 1'b0, "R4", hs_valid, 0);
      check(csr_rdata == 16'h0, "R4", csr_rdata, 0);
      send_pkt(6, 1, 8'h50, 0);
      check(hs_valid == 1'b0, "R11", hs_valid, 0);
      check(csr_rdata == 16'h0, "R11", csr_rdata, 0);
      send_pkt(2, 1, 8'h60, 1);
      check(hs_valid && hs_ack, "R4", {hs_valid, hs_ack}, 3);
      check(csr_rdata == 16'h0023, "R4", csr_rdata, 16'h0023);
      drain(2, 8'h60, "R4");
      write_csr(16'h0002);
      check(csr_rdata == 16'h0, "R4", csr_rdata, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_single();
      t_pingpong();
      t_zero();
      t_bad();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule